// File: doc/BRIEF.md
# Scatter-Gather Hash DMA Front End

This block sits in front of a message-digest engine and feeds it data fetched from memory. Software programs a source pointer, a digest destination pointer, a total byte count and a command word over a simple 32-bit register bus. The command write launches the job. The job then either streams one contiguous buffer, or walks a list of segment descriptors and streams each segment in list order. Bytes go out one word at a time on a valid/ready interface toward the hash core. A byte-valid mask marks the live bytes of each word.

Memory is reached through a word-wide read port that has one request in flight at a time. Each read is a single-cycle request pulse, answered later by a response strobe that carries the data. The hash core itself is outside the block. Only its data handshake is present, together with the decoded algorithm, the SHA byte-order flag and the digest destination, all held stable for the duration of the job. Software learns the result by polling a status word. That word holds a busy bit, a sticky completion flag cleared by writing one to it, and an error bit.

Top module: `sg_hash_frontend`

## Requirements
- R1: After reset the status word (offset 0x1C) reads 0. Bit 0 is busy, bit 9 is completion and bit 16 is error.
- R2: The source (0x20), digest (0x24), length (0x2C) and command (0x30) registers read back what was written. Any other offset reads 0. Read data appears one cycle after the read strobe.
- R3: In direct mode (command bit 18 clear), exactly the programmed number of bytes are streamed from the source address upward. The low two address bits are ignored. A full word carries byte-valid 4'hF and a final partial word carries 4'h1, 4'h3 or 4'h7. Byte k of a beat is data[8k+7:8k]. A stalled beat holds its data and mask.
- R4: In scatter-gather mode (command bit 18 set), the source address points at a list of 8-byte descriptors. Each descriptor is a length word followed by an address word. Bits 30:0 of the length word give the segment byte count and bit 31 marks the final entry. Segments are streamed in list order. Only one memory read is outstanding at a time.
- R5: The completion flag is sticky. A write to 0x1C with bit 9 set clears it, and a write with bit 9 clear leaves it set.
- R6: A command write that arrives while busy is set is ignored. It does not change the running job, the command register or the streamed bytes.
- R7: Busy reads 1 from the accepted command write until the last byte has been accepted by the hash core. In the same cycle that busy drops, completion is set. No memory request or data beat occurs while busy is 0.
- R8: A job is rejected immediately, setting error and completion with no memory reads and no busy period, in two cases: a digest address whose low 3 bits are not zero, or a source address whose bit 31 is 0.
- R9: If 32 descriptors are consumed without an end marker, the job stops after exactly 64 descriptor reads with error and completion set. An end marker in the 32rd entry completes normally.
- R10: When the end marker is reached and the streamed byte total differs from the length register, error is set. The bytes are still streamed.
- R11: The command bits 10, 6, 5, 4 select the algorithm. The encodings are: 0x000 MD5 (code 0), 0x020 SHA-1 (1), 0x040 SHA-224 (2), 0x050 SHA-256 (3), 0x060 SHA-512 (4) and 0x460 SHA-384 (5). They appear on hc_alg with command bit 3 on hc_be. Any other encoding is rejected as in R8.
- R12: A descriptor with a zero byte count produces no data reads and no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Single-cycle memory read request |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Read response data |
| hc_valid | output | 1 | Data beat valid toward hash core |
| hc_data | output | 32 | Data beat |
| hc_bvalid | output | 4 | Byte-valid mask of the beat |
| hc_ready | input | 1 | Hash core accepts the beat |
| hc_alg | output | 3 | Decoded algorithm code of the current job |
| hc_be | output | 1 | SHA big-endian ordering selected |
| hc_dst | output | 32 | Digest destination address of the current job |

## Verification
A walker state that goes wrong shows up first on the memory port. A descriptor pointer that advances wrongly fetches a wrong address within two reads, and a bad segment counter adds or drops a beat at the end of the first segment. Errors in the register side appear in the status word one read after the job should have finished: a busy that never clears, a completion that is missing or lingers, or an error bit on a length that matched. The byte stream is compared position by position with a memory pattern tied to the address. The memory-request count and the last byte-valid mask expose slips of a word or of a byte.

// File: rtl/sgh_pkg.sv
package sgh_pkg;
  localparam logic [7:0] OFS_STAT = 8'h1C;
  localparam logic [7:0] OFS_SRC  = 8'h20;
  localparam logic [7:0] OFS_DST  = 8'h24;
  localparam logic [7:0] OFS_LEN  = 8'h2C;
  localparam logic [7:0] OFS_CMD  = 8'h30;

  localparam int BIT_BUSY = 0;
  localparam int BIT_DONE = 9;
  localparam int BIT_ERR  = 16;
  localparam int BIT_SG   = 18;
  localparam int BIT_BE   = 3;

  localparam logic [31:0] ALG_FIELD = 32'h0000_0470;

  typedef enum logic [2:0] {
    ALG_MD5, ALG_SHA1, ALG_SHA224, ALG_SHA256, ALG_SHA512, ALG_SHA384, ALG_BAD
  } alg_e;

  typedef enum logic [3:0] {
    W_IDLE, W_LREQ, W_LWAIT, W_AREQ, W_AWAIT, W_SEG,
    W_DREQ, W_DWAIT, W_PUSH, W_SEGEND
  } wstate_e;

  function automatic alg_e alg_decode(input logic [31:0] c);
    case (c & ALG_FIELD)
      32'h0000_0000: return ALG_MD5;
      32'h0000_0020: return ALG_SHA1;
      32'h0000_0040: return ALG_SHA224;
      32'h0000_0050: return ALG_SHA256;
      32'h0000_0060: return ALG_SHA512;
      32'h0000_0460: return ALG_SHA384;
      default:       return ALG_BAD;
    endcase
  endfunction
endpackage

// File: rtl/sgh_regs.sv
module sgh_regs
  import sgh_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          go,
  output logic [DW-1:0] job_src,
  output logic [DW-1:0] job_len,
  output logic [DW-1:0] job_dst,
  output logic          job_sg,
  output logic          job_be,
  output alg_e          job_alg,
  input  logic          fin,
  input  logic          fin_err,
  output logic          st_busy,
  output logic          st_done,
  output logic          st_err
);
  logic [DW-1:0] src_q, dst_q, len_q, cmd_q, sts;
  logic          cmd_hit, start_ok, bad_job;
  alg_e          new_alg;

  assign cmd_hit  = reg_wr && (reg_addr == AW'(OFS_CMD));
  assign start_ok = cmd_hit && !st_busy;
  assign new_alg  = alg_decode(reg_wdata);
  assign bad_job  = (new_alg == ALG_BAD) || (dst_q[2:0] != 3'b000) || !src_q[DW-1];

  always_comb begin
    sts = '0;
    sts[BIT_BUSY] = st_busy;
    sts[BIT_DONE] = st_done;
    sts[BIT_ERR]  = st_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0; dst_q <= '0; len_q <= '0; cmd_q <= '0;
      job_src <= '0; job_len <= '0; job_dst <= '0;
      job_sg <= 1'b0; job_be <= 1'b0; job_alg <= ALG_MD5;
      go <= 1'b0; st_busy <= 1'b0; st_done <= 1'b0; st_err <= 1'b0;
      reg_rdata <= '0;
    end else begin
      go <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          AW'(OFS_SRC):  src_q <= reg_wdata;
          AW'(OFS_DST):  dst_q <= reg_wdata;
          AW'(OFS_LEN):  len_q <= reg_wdata;
          AW'(OFS_STAT): if (reg_wdata[BIT_DONE]) st_done <= 1'b0;
          default: ;
        endcase
      end
      if (start_ok) begin
        cmd_q <= reg_wdata;
        if (bad_job) begin
          st_done <= 1'b1;
          st_err  <= 1'b1;
        end else begin
          st_busy <= 1'b1;
          st_err  <= 1'b0;
          go      <= 1'b1;
          job_src <= src_q;
          job_len <= len_q;
          job_dst <= dst_q;
          job_sg  <= reg_wdata[BIT_SG];
          job_be  <= reg_wdata[BIT_BE];
          job_alg <= new_alg;
        end
      end
      if (fin) begin
        st_busy <= 1'b0;
        st_done <= 1'b1;
        st_err  <= fin_err;
      end
      if (reg_rd) begin
        case (reg_addr)
          AW'(OFS_STAT): reg_rdata <= sts;
          AW'(OFS_SRC):  reg_rdata <= src_q;
          AW'(OFS_DST):  reg_rdata <= dst_q;
          AW'(OFS_LEN):  reg_rdata <= len_q;
          AW'(OFS_CMD):  reg_rdata <= cmd_q;
          default:       reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sgh_walker.sv
module sgh_walker
  import sgh_pkg::*;
#(
  parameter int DW       = 32,
  parameter int MAX_DESC = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] job_src,
  input  logic [DW-1:0] job_len,
  input  logic          job_sg,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          hc_valid,
  output logic [DW-1:0] hc_data,
  output logic [3:0]    hc_bvalid,
  input  logic          hc_ready,
  output logic          fin,
  output logic          fin_err
);
  localparam int DIW  = $clog2(MAX_DESC + 1);
  localparam int BPW  = DW / 8;

  wstate_e        st;
  logic [DW-1:0]  ptr, seg_addr, seg_rem, sent, take;
  logic           seg_last;
  logic [DIW-1:0] didx;
  logic [3:0]     tail_mask;

  assign take = (seg_rem >= DW'(BPW)) ? DW'(BPW) : seg_rem;

  always_comb begin
    case (seg_rem[1:0])
      2'd1:    tail_mask = 4'h1;
      2'd2:    tail_mask = 4'h3;
      2'd3:    tail_mask = 4'h7;
      default: tail_mask = 4'hF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= W_IDLE; ptr <= '0; seg_addr <= '0; seg_rem <= '0; sent <= '0;
      seg_last <= 1'b0; didx <= '0;
      mem_req <= 1'b0; mem_addr <= '0;
      hc_valid <= 1'b0; hc_data <= '0; hc_bvalid <= '0;
      fin <= 1'b0; fin_err <= 1'b0;
    end else begin
      fin     <= 1'b0;
      mem_req <= 1'b0;
      case (st)
        W_IDLE: if (go) begin
          sent <= '0;
          didx <= '0;
          if (job_sg) begin
            ptr <= job_src;
            st  <= W_LREQ;
          end else begin
            seg_addr <= job_src;
            seg_rem  <= job_len;
            seg_last <= 1'b1;
            st       <= W_SEG;
          end
        end
        W_LREQ: begin
          mem_req  <= 1'b1;
          mem_addr <= {ptr[DW-1:2], 2'b00};
          st       <= W_LWAIT;
        end
        W_LWAIT: if (mem_rvalid) begin
          seg_last <= mem_rdata[DW-1];
          seg_rem  <= {1'b0, mem_rdata[DW-2:0]};
          st       <= W_AREQ;
        end
        W_AREQ: begin
          mem_req  <= 1'b1;
          mem_addr <= {ptr[DW-1:2], 2'b00} + DW'(4);
          st       <= W_AWAIT;
        end
        W_AWAIT: if (mem_rvalid) begin
          seg_addr <= mem_rdata;
          st       <= W_SEG;
        end
        W_SEG: st <= (seg_rem == '0) ? W_SEGEND : W_DREQ;
        W_DREQ: begin
          mem_req  <= 1'b1;
          mem_addr <= {seg_addr[DW-1:2], 2'b00};
          st       <= W_DWAIT;
        end
        W_DWAIT: if (mem_rvalid) begin
          hc_valid  <= 1'b1;
          hc_data   <= mem_rdata;
          hc_bvalid <= (seg_rem >= DW'(BPW)) ? 4'hF : tail_mask;
          st        <= W_PUSH;
        end
        W_PUSH: if (hc_ready) begin
          hc_valid <= 1'b0;
          seg_rem  <= seg_rem - take;
          sent     <= sent + take;
          seg_addr <= seg_addr + DW'(BPW);
          st       <= (seg_rem <= DW'(BPW)) ? W_SEGEND : W_DREQ;
        end
        W_SEGEND: begin
          if (seg_last) begin
            fin     <= 1'b1;
            fin_err <= (sent != job_len);
            st      <= W_IDLE;
          end else if (didx == DIW'(MAX_DESC - 1)) begin
            fin     <= 1'b1;
            fin_err <= 1'b1;
            st      <= W_IDLE;
          end else begin
            didx <= didx + DIW'(1);
            ptr  <= ptr + DW'(8);
            st   <= W_LREQ;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_hash_frontend.sv
module sg_hash_frontend
  import sgh_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int MAX_DESC = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          hc_valid,
  output logic [DW-1:0] hc_data,
  output logic [3:0]    hc_bvalid,
  input  logic          hc_ready,
  output logic [2:0]    hc_alg,
  output logic          hc_be,
  output logic [DW-1:0] hc_dst
);
  logic          go, fin, fin_err, job_sg;
  logic          st_busy, st_done, st_err;
  logic [DW-1:0] job_src, job_len;
  alg_e          job_alg;

  assign hc_alg = job_alg;

  sgh_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .go(go),
    .job_src(job_src), .job_len(job_len), .job_dst(hc_dst),
    .job_sg(job_sg), .job_be(hc_be), .job_alg(job_alg),
    .fin(fin), .fin_err(fin_err),
    .st_busy(st_busy), .st_done(st_done), .st_err(st_err)
  );

  sgh_walker #(.DW(DW), .MAX_DESC(MAX_DESC)) u_walk (
    .clk(clk), .rst(rst), .go(go), .job_src(job_src), .job_len(job_len),
    .job_sg(job_sg), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .hc_valid(hc_valid), .hc_data(hc_data), .hc_bvalid(hc_bvalid),
    .hc_ready(hc_ready), .fin(fin), .fin_err(fin_err)
  );
endmodule

// File: rtl/sgh_checker.sv
module sgh_checker #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          mem_req,
  input logic          hc_valid,
  input logic          hc_ready,
  input logic [DW-1:0] hc_data,
  input logic [3:0]    hc_bvalid,
  input logic          go,
  input logic          st_busy,
  input logic          st_done
);
  // R3: a stalled beat keeps its contents
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    hc_valid && !hc_ready |=> hc_valid && $stable(hc_data) && $stable(hc_bvalid));

  // R3: byte-valid is a non-empty low-aligned mask
  assert_mask_shape_R3: assert property (@(posedge clk) disable iff (rst)
    hc_valid |-> (hc_bvalid != 4'h0) && ((hc_bvalid & (hc_bvalid + 4'h1)) == 4'h0));

  // R4: one memory read in flight, requests are single pulses
  assert_single_req_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R7: no traffic outside a busy period
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !st_busy |-> !mem_req && !hc_valid);

  // R6: a job launch only follows a command write made while idle
  assert_launch_idle_R6: assert property (@(posedge clk) disable iff (rst)
    go |-> !$past(st_busy) && $past(reg_wr) && ($past(reg_addr) == AW'(8'h30)));

  // R5: completion only clears through a write-one to the status offset
  assert_done_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(st_done) |-> $past(reg_wr) && ($past(reg_addr) == AW'(8'h1C)) && $past(reg_wdata[9]));
endmodule

bind sg_hash_frontend sgh_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .hc_valid(hc_valid), .hc_ready(hc_ready), .hc_data(hc_data),
  .hc_bvalid(hc_bvalid), .go(go), .st_busy(st_busy), .st_done(st_done)
);

// File: tb/sim_sg_hash_frontend.sv
`timescale 1ns/1ps
module sim_sg_hash_frontend;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        hc_valid, hc_ready, hc_be;
  logic [31:0] hc_data, hc_dst;
  logic [3:0]  hc_bvalid;
  logic [2:0]  hc_alg;

  int total = 0, bad = 0;

  logic [31:0] mem [0:1023];
  logic        p1 = 1'b0;
  logic [31:0] q1 = '0;
  logic [7:0]  cap_byte [0:255];
  int          ncap = 0, nbeat = 0, nreq = 0;
  logic [3:0]  last_bv = '0;
  logic        cap_clr = 1'b0;
  logic [7:0]  rcnt = '0;

  always #10 clk = ~clk;

  sg_hash_frontend u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .hc_valid(hc_valid), .hc_data(hc_data),
    .hc_bvalid(hc_bvalid), .hc_ready(hc_ready), .hc_alg(hc_alg), .hc_be(hc_be), .hc_dst(hc_dst)
  );

  function automatic logic [7:0] eb(input logic [31:0] a);
    return a[7:0] ^ {4'h0, a[11:8]} ^ 8'hA5;
  endfunction

  assign hc_ready = (rcnt[1:0] != 2'd3);

  always @(posedge clk) begin
    rcnt <= rcnt + 8'd1;
    p1 <= mem_req;
    q1 <= mem_addr;
    mem_rvalid <= p1;
    mem_rdata  <= mem[q1[11:2]];
  end

  always @(posedge clk) begin
    if (cap_clr) begin
      ncap <= 0; nbeat <= 0; nreq <= 0; last_bv <= '0;
    end else begin
      if (mem_req) nreq <= nreq + 1;
      if (hc_valid && hc_ready) begin
        int j;
        j = ncap;
        for (int k = 0; k < 4; k++)
          if (hc_bvalid[k] && j < 256) begin
            cap_byte[j] <= hc_data[8*k +: 8];
            j++;
          end
        ncap <= j;
        nbeat <= nbeat + 1;
        last_bv <= hc_bvalid;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic clear_all();
    wr(8'h1C, 32'h0000_0200);
    @(negedge clk); cap_clr = 1'b1;
    @(negedge clk); cap_clr = 1'b0;
  endtask

  task automatic wait_done(input string req, output logic [31:0] s);
    s = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h1C, s);
      if (s[9]) break;
    end
    check({req, " completion seen"}, {31'b0, s[9]}, 32'd1);
    repeat (2) @(negedge clk);
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] l, input logic [31:0] ad);
    mem[at[11:2]] = l;
    mem[at[11:2] + 10'd1] = ad;
  endtask

  task automatic check_stream(input string req, input logic [31:0] a0, input int n, input int off);
    for (int i = 0; i < n; i++)
      check(req, {24'b0, cap_byte[off + i]}, {24'b0, eb(a0 + i)});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h1C, v); check("R1 status after reset", v, 32'h0);
    rd(8'h20, v); check("R2 source after reset", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h20, 32'h8000_0800); wr(8'h24, 32'h8000_0040); wr(8'h2C, 32'd10);
    rd(8'h20, v); check("R2 source readback", v, 32'h8000_0800);
    rd(8'h24, v); check("R2 digest readback", v, 32'h8000_0040);
    rd(8'h2C, v); check("R2 length readback", v, 32'd10);
    rd(8'h04, v); check("R2 unmapped offset", v, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    clear_all();
    wr(8'h20, 32'h8000_0800); wr(8'h24, 32'h8000_0040); wr(8'h2C, 32'd10);
    wr(8'h30, 32'h0000_0058);
    rd(8'h1C, v); check("R7 busy during job", v & 32'h1, 32'h1);
    wait_done("R3", v);
    check("R7 status after direct job", v, 32'h0000_0200);
    check("R3 byte count", ncap, 10);
    check("R3 beat count", nbeat, 3);
    check("R3 tail mask", {28'b0, last_bv}, 32'h3);
    check("R3 memory reads", nreq, 3);
    check_stream("R3 byte stream", 32'h8000_0800, 10, 0);
    check("R11 SHA-256 code", {29'b0, hc_alg}, 32'd3);
    check("R11 big-endian flag", {31'b0, hc_be}, 32'd1);
    check("R11 digest pointer", hc_dst, 32'h8000_0040);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); check("R5 done survives write of 0", v, 32'h0000_0200);
    wr(8'h1C, 32'h0000_0200);
    rd(8'h1C, v); check("R5 done cleared by write-one", v, 32'h0);
  endtask

  task automatic setup_sg_list();
    put_desc(32'h8000_0100, 32'd5, 32'h8000_0900);
    put_desc(32'h8000_0108, 32'd0, 32'h8000_0A00);
    put_desc(32'h8000_0110, 32'h8000_0007, 32'h8000_0A10);
  endtask

  task automatic t_sg();
    logic [31:0] v;
    clear_all();
    setup_sg_list();
    wr(8'h20, 32'h8000_0100); wr(8'h2C, 32'd12);
    wr(8'h30, 32'h0004_0020);
    wait_done("R4", v);
    check("R4 status after list walk", v, 32'h0000_0200);
    check("R4 byte count", ncap, 12);
    check("R12 zero segment adds no beats", nbeat, 4);
    check("R12 memory reads", nreq, 10);
    check_stream("R4 first segment", 32'h8000_0900, 5, 0);
    check_stream("R4 last segment", 32'h8000_0A10, 7, 5);
    check("R11 SHA-1 code", {29'b0, hc_alg}, 32'd1);
    check("R11 little-endian flag", {31'b0, hc_be}, 32'd0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    clear_all();
    setup_sg_list();
    wr(8'h20, 32'h8000_0100); wr(8'h2C, 32'd12);
    wr(8'h30, 32'h0004_0060);
    wr(8'h30, 32'h0000_0050);
    wait_done("R6", v);
    check("R6 status", v, 32'h0000_0200);
    rd(8'h30, v); check("R6 command register unchanged", v, 32'h0004_0060);
    check("R6 byte count", ncap, 12);
    check("R6 memory reads", nreq, 10);
    check_stream("R6 stream", 32'h8000_0A10, 7, 5);
    check("R11 SHA-512 code", {29'b0, hc_alg}, 32'd4);
  endtask

  task automatic t_reject();
    logic [31:0] v;
    clear_all();
    wr(8'h20, 32'h8000_0800); wr(8'h24, 32'h8000_0044); wr(8'h2C, 32'd4);
    wr(8'h30, 32'h0000_0050);
    rd(8'h1C, v); check("R8 misaligned digest rejected", v, 32'h0001_0200);
    repeat (10) @(negedge clk);
    check("R8 no reads on reject", nreq, 0);
    clear_all();
    wr(8'h20, 32'h0000_0800); wr(8'h24, 32'h8000_0040);
    wr(8'h30, 32'h0000_0050);
    rd(8'h1C, v); check("R8 source outside window rejected", v, 32'h0001_0200);
    clear_all();
    wr(8'h20, 32'h8000_0800);
    wr(8'h30, 32'h0000_0010);
    rd(8'h1C, v); check("R11 unknown algorithm rejected", v, 32'h0001_0200);
    repeat (10) @(negedge clk);
    check("R8 no reads or beats", nreq + nbeat, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    clear_all();
    for (int i = 0; i < 32; i++)
      put_desc(32'h8000_0400 + 32'(i * 8), 32'd0, 32'h8000_0800);
    wr(8'h20, 32'h8000_0400); wr(8'h2C, 32'd0);
    wr(8'h30, 32'h0004_0050);
    wait_done("R9", v);
    check("R9 list without marker", v, 32'h0001_0200);
    check("R9 descriptor reads", nreq, 64);
    clear_all();
    put_desc(32'h8000_04F8, 32'h8000_0000, 32'h8000_0800);
    wr(8'h30, 32'h0004_0050);
    wait_done("R9", v);
    check("R9 marker in last slot", v, 32'h0000_0200);
    check("R9 descriptor reads with marker", nreq, 64);
  endtask

  task automatic t_mismatch();
    logic [31:0] v;
    clear_all();
    put_desc(32'h8000_0200, 32'h8000_0006, 32'h8000_0900);
    wr(8'h20, 32'h8000_0200); wr(8'h2C, 32'd8);
    wr(8'h30, 32'h0004_0040);
    wait_done("R10", v);
    check("R10 length mismatch flagged", v, 32'h0001_0200);
    check("R10 bytes still streamed", ncap, 6);
    check("R10 tail mask", {28'b0, last_bv}, 32'h3);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++)
      for (int k = 0; k < 4; k++)
        mem[i][8*k +: 8] = eb(32'(i * 4 + k));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_direct();
    t_sticky();
    t_sg();
    t_busy_ignore();
    t_reject();
    t_overflow();
    t_mismatch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule